// File: doc/BRIEF.md
# Prioritised Interrupt Claim Controller

This block gathers level-sensitive interrupt requests from a set of peripheral sources and presents a single external interrupt line to one machine-mode hart context. Each source is latched into a pending bit. It is gated by a per-source enable and ranked by a small programmable priority. Only sources whose priority is strictly above a target threshold may raise the line.

Software reaches the block through a plain valid/ready register port. A handler reads the claim register and receives the ID of the best eligible source. That read also removes the source from the pending set and marks it as in service. Once the handler is done, it writes the same ID back to that register. Until that write arrives, the source cannot become pending again, even if its request line is still high.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset every priority, every enable, the threshold and every pending bit read 0, `irq_o` is low and a claim read returns 0.
- R2: The priority of source i (1..26) lives at byte address 4*i, bits [2:0]; upper bits read 0; address 0 (the reserved ID 0 slot) reads 0 and ignores writes.
- R3: A source held high while idle sets its pending bit; the pending word at 0x1000 shows source i in bit i (bit 0 always 0), and writes to it change nothing.
- R4: The enable word at 0x2000 gates source i with bit i; bit 0 and bits above 26 read 0.
- R5: `irq_o` is high exactly when some source is pending, enabled and has priority greater than the threshold; a source with priority 0 never raises it.
- R6: A read of 0x200004 returns the eligible source with the highest priority, the lower ID on a tie, or 0 when none is eligible.
- R7: A claim clears that source's pending bit, and the source stays non-pending while in service, whatever its input does.
- R8: Writing a source ID (1..26) to 0x200004 ends its service; if its input is still high it becomes pending again, otherwise it stays clear.
- R9: The threshold lives at 0x200000, bits [2:0], and raising it to or above a source's priority masks that source.
- R10: `req_ready_o` is always high; every read gets exactly one `rsp_valid_o` pulse in the following cycle, writes get none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | 26 | Level request of sources 26..1 (bit i is source i) |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Register request accepted |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 24 | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |
| irq_o | output | 1 | External interrupt to the hart |

## Verification
The hardest state to reach is a source that is in service while its input is still high. From the outside, a correct controller and one that forgets the in-service mark look alike until the complete write arrives. The stimulus claims a source, keeps its line asserted for several cycles and reads the pending word, which must stay clear. It then completes the source and shows that the bit returns. It also completes a source whose line has dropped, and shows that the bit stays clear. Tie-breaking between equal priorities and threshold masking are reached by successive claims on the same set of held sources.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam logic [31:0] PEND_BASE  = 32'h0000_1000;
    localparam logic [31:0] EN_BASE    = 32'h0000_2000;
    localparam logic [31:0] THR_ADDR   = 32'h0020_0000;
    localparam logic [31:0] CLAIM_ADDR = 32'h0020_0004;

    typedef struct packed {
        logic pending;
        logic busy;
    } gate_state_t;
endpackage

// File: rtl/irq_gate.sv
module irq_gate
    import irq_arb_pkg::*;
#(
    parameter int ID_W = 5,
    parameter int ID   = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            src_i,
    input  logic            claim_i,
    input  logic [ID_W-1:0] claim_id_i,
    input  logic            cmp_i,
    input  logic [ID_W-1:0] cmp_id_i,
    output logic            pend_o
);
    gate_state_t st_d, st_q;
    logic claim_hit, cmp_hit;

    always_comb begin
        claim_hit = claim_i && (claim_id_i == ID_W'(ID));
        cmp_hit   = cmp_i && (cmp_id_i == ID_W'(ID));
        st_d      = st_q;
        if (claim_hit && st_q.pending) begin
            st_d.pending = 1'b0;
            st_d.busy    = 1'b1;
        end else begin
            if (cmp_hit) st_d.busy = 1'b0;
            if (!st_q.busy && !st_q.pending && src_i) st_d.pending = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pending;

    // R7
    busy_blocks_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> !st_q.pending);
    // R7
    claim_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_hit && st_q.pending) |=> (st_q.busy && !st_q.pending));
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int NUM_SRC = 26,
    parameter int PRIO_W  = 3,
    parameter int ID_W    = 5
) (
    input  logic [NUM_SRC:1]             pend_i,
    input  logic [NUM_SRC:1]             en_i,
    input  logic [NUM_SRC:1][PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]            thr_i,
    output logic [ID_W-1:0]              id_o,
    output logic [PRIO_W-1:0]            prio_o
);
    always_comb begin
        id_o   = '0;
        prio_o = '0;
        for (int i = 1; i <= NUM_SRC; i++) begin
            // strict compare keeps the lower ID on equal priority
            if (pend_i[i] && en_i[i] && (prio_i[i] > thr_i) && (prio_i[i] > prio_o)) begin
                id_o   = ID_W'(i);
                prio_o = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 26,
    parameter int PRIO_W  = 3,
    parameter int ADDR_W  = 24,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC:1]  irq_src_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_rdata_o,
    output logic              irq_o
);
    localparam int ID_W   = $clog2(NUM_SRC + 1);
    localparam int NWORDS = (NUM_SRC + DATA_W) / DATA_W;

    typedef struct packed {
        logic [NUM_SRC:1][PRIO_W-1:0] prio;
        logic [NUM_SRC:1]             en;
        logic [PRIO_W-1:0]            thr;
        logic                         rsp_v;
        logic [DATA_W-1:0]            rsp_d;
    } regs_t;

    regs_t r_d, r_q;

    logic [NUM_SRC:1]   pend;
    logic [ID_W-1:0]    sel_id;
    logic [PRIO_W-1:0]  sel_prio;
    logic [31:0]        aw;
    logic [DATA_W-1:0]  rd;
    logic               rd_req, wr_req;
    logic               claim_v, cmp_v;
    logic [ID_W-1:0]    cmp_id;

    irq_pick #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_pick (
        .pend_i (pend),
        .en_i   (r_q.en),
        .prio_i (r_q.prio),
        .thr_i  (r_q.thr),
        .id_o   (sel_id),
        .prio_o (sel_prio)
    );

    for (genvar g = 1; g <= NUM_SRC; g++) begin : g_gate
        irq_gate #(.ID_W(ID_W), .ID(g)) u_gate (
            .clk        (clk),
            .rst_n      (rst_n),
            .src_i      (irq_src_i[g]),
            .claim_i    (claim_v),
            .claim_id_i (sel_id),
            .cmp_i      (cmp_v),
            .cmp_id_i   (cmp_id),
            .pend_o     (pend[g])
        );
    end

    always_comb begin
        r_d       = r_q;
        r_d.rsp_v = 1'b0;
        r_d.rsp_d = '0;
        aw        = 32'(req_addr_i);
        rd_req    = req_valid_i && !req_write_i;
        wr_req    = req_valid_i && req_write_i;
        rd        = '0;
        claim_v   = 1'b0;
        cmp_v     = 1'b0;
        cmp_id    = req_wdata_i[ID_W-1:0];

        for (int i = 1; i <= NUM_SRC; i++) begin
            if (aw == 32'(4 * i)) begin
                rd[PRIO_W-1:0] = r_q.prio[i];
                if (wr_req) r_d.prio[i] = req_wdata_i[PRIO_W-1:0];
            end
        end

        for (int w = 0; w < NWORDS; w++) begin
            if (aw == PEND_BASE + 32'(4 * w)) begin
                for (int i = 1; i <= NUM_SRC; i++)
                    if (i / DATA_W == w) rd[i % DATA_W] = pend[i];
            end
            if (aw == EN_BASE + 32'(4 * w)) begin
                for (int i = 1; i <= NUM_SRC; i++) begin
                    if (i / DATA_W == w) begin
                        rd[i % DATA_W] = r_q.en[i];
                        if (wr_req) r_d.en[i] = req_wdata_i[i % DATA_W];
                    end
                end
            end
        end

        if (aw == THR_ADDR) begin
            rd[PRIO_W-1:0] = r_q.thr;
            if (wr_req) r_d.thr = req_wdata_i[PRIO_W-1:0];
        end

        if (aw == CLAIM_ADDR) begin
            rd[ID_W-1:0] = sel_id;
            claim_v      = rd_req && (sel_id != '0);
            cmp_v        = wr_req && (req_wdata_i != '0)
                           && (req_wdata_i <= DATA_W'(NUM_SRC));
        end

        if (rd_req) begin
            r_d.rsp_v = 1'b1;
            r_d.rsp_d = rd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign req_ready_o = 1'b1;
    assign rsp_valid_o = r_q.rsp_v;
    assign rsp_rdata_o = r_q.rsp_d;
    assign irq_o       = (sel_id != '0);

    // R10
    rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_write_i) |=> rsp_valid_o);
    // R10
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid_i && !req_write_i) |=> !rsp_valid_o);
    // R5
    irq_above_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (sel_prio > r_q.thr));
    // R6
    claim_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_write_i && aw == CLAIM_ADDR && irq_o) |=> (rsp_rdata_o != '0));
endmodule

// File: tb/irq_prio_arbiter_test.sv
module irq_prio_arbiter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [26:1] src = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    localparam logic [23:0] PEND  = 24'h001000;
    localparam logic [23:0] ENAB  = 24'h002000;
    localparam logic [23:0] THR   = 24'h200000;
    localparam logic [23:0] CLAIM = 24'h200004;

    always #4 clk = ~clk;

    irq_prio_arbiter uut (
        .clk(clk), .rst_n(rst_n), .irq_src_i(src),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .irq_o(irq)
    );

    // monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R10 unexpected response actual=%h expected=none", rsp_rdata);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (rsp_rdata !== e) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", t, rsp_rdata, e);
                end
            end
        end
    end

    task automatic rd(input logic [23:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wr(input logic [23:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk_irq(input logic e, input string t);
        @(negedge clk);
        checks++;
        if (irq !== e) begin
            failures++;
            $display("FAIL %s irq actual=%b expected=%b", t, irq, e);
        end
    endtask

    initial begin
        #(8 * 100000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle(2);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk_irq(1'b0, "R1 reset irq");
        checks++;
        if (req_ready !== 1'b1) begin
            failures++;
            $display("FAIL R10 ready actual=%b expected=1", req_ready);
        end
        rd(24'd20, 32'h0, "R1 prio5 reset");
        rd(THR, 32'h0, "R1 thr reset");
        rd(ENAB, 32'h0, "R1 enable reset");
        rd(PEND, 32'h0, "R1 pending reset");
        rd(CLAIM, 32'h0, "R1 claim reset");

        // R2 priority width and reserved slot
        wr(24'd20, 32'hFFFF_FFFF);
        rd(24'd20, 32'h7, "R2 prio5 truncated");
        wr(24'd0, 32'h5);
        rd(24'd0, 32'h0, "R2 slot0 reads zero");

        // R3 pending latch, read-only
        src[5] = 1'b1;
        idle(3);
        rd(PEND, 32'h20, "R3 pending bit5");
        wr(PEND, 32'h0);
        rd(PEND, 32'h20, "R3 pending write ignored");
        chk_irq(1'b0, "R5 disabled source silent");

        // R4 enable word
        wr(ENAB, 32'hFFFF_FFFF);
        rd(ENAB, 32'h07FF_FFFE, "R4 enable mask");
        chk_irq(1'b1, "R5 enabled source raises");

        // R9 threshold
        wr(THR, 32'h7);
        rd(THR, 32'h7, "R9 thr readback");
        chk_irq(1'b0, "R9 thr equal masks");
        rd(CLAIM, 32'h0, "R6 claim none eligible");
        wr(THR, 32'h0);

        // R7 claim and in-service gating; source 3 has priority 0
        src[3] = 1'b1;
        idle(3);
        rd(CLAIM, 32'd5, "R6 claim source5");
        rd(PEND, 32'h8, "R7 claim clears bit5");
        chk_irq(1'b0, "R5 priority0 never interrupts");
        idle(5);
        rd(PEND, 32'h8, "R7 held source stays clear");
        rd(CLAIM, 32'h0, "R6 only priority0 pending");

        // R8 complete with line high, then with line low
        wr(CLAIM, 32'd5);
        idle(2);
        rd(PEND, 32'h28, "R8 re-pended after complete");
        rd(CLAIM, 32'd5, "R8 reclaim source5");
        src[5] = 1'b0;
        wr(CLAIM, 32'd5);
        idle(3);
        rd(PEND, 32'h8, "R8 dropped source stays clear");

        // R6 ties go to the lower ID
        wr(24'd40, 32'h4);
        wr(24'd48, 32'h4);
        src[10] = 1'b1; src[12] = 1'b1;
        idle(3);
        rd(CLAIM, 32'd10, "R6 tie lower id first");
        rd(CLAIM, 32'd12, "R6 tie second");
        rd(CLAIM, 32'd0, "R6 none left");
        wr(CLAIM, 32'd10);
        wr(CLAIM, 32'd12);
        idle(2);
        rd(PEND, 32'h1408, "R8 both re-pended");

        // R6 higher priority wins over lower ID
        wr(24'd80, 32'h6);
        src[20] = 1'b1;
        idle(3);
        rd(CLAIM, 32'd20, "R6 higher priority wins");

        // R9 threshold masks equal priority
        wr(THR, 32'h4);
        chk_irq(1'b0, "R9 thr4 masks prio4");
        rd(CLAIM, 32'd0, "R9 claim masked");
        wr(THR, 32'h3);
        chk_irq(1'b1, "R9 thr3 passes prio4");
        rd(CLAIM, 32'd10, "R9 claim after lowering");

        idle(4);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R10 missing responses actual=%0d expected=0", exp_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule